// File: doc/BRIEF.md
# Indexed Byte Port onto Non-Volatile RAM

This block puts a byte-wide RAM behind a four-location I/O window. Software first loads a 16-bit index, one byte at a time, into two latch locations. It then reads or writes the selected RAM byte through a third location, the data port. Every data write clears the index to zero, so each write needs a fresh index. The fourth location is reserved.

Two fixed 16-byte windows of the RAM can be hidden one at a time. Window 0 covers indices 0x20..0x2F and window 1 covers 0x30..0x3F. While a window is hidden, reads inside it return 0xFF and writes inside it are dropped. The bytes stored there are left as they were and can be seen again once the window is opened. A one-cycle toggle request with a window number flips that window's hide bit. Any index at or above the RAM size reads as 0xFF and ignores writes. The RAM itself is not reset, because in use it is backed by a battery.

Top module: `nvram_index_port`

## Requirements
- R1: After reset (rst_ni low), the index is 0x0000, both windows are open, and io_rdata_o is 0xFF. Reset does not change the RAM contents.
- R2: A write to offset 0 loads io_wdata_i into index bits 7:0. Index bits 15:8 keep their value.
- R3: A write to offset 1 loads io_wdata_i into index bits 15:8. Index bits 7:0 keep their value.
- R4: A write to offset 3 stores io_wdata_i at the RAM byte selected by the index, then sets the index to 0x0000. The index is cleared even when the store itself is dropped.
- R5: A read of offset 3 returns the RAM byte selected by the index. The read leaves the index unchanged.
- R6: A write to offset 2 has no effect. A read of offset 0, 1 or 2 returns 0xFF.
- R7: While lock bit 0 is set, reads of indices 0x20..0x2F return 0xFF and writes to them are dropped.
- R8: While lock bit 1 is set, reads of indices 0x30..0x3F return 0xFF and writes to them are dropped.
- R9: A cycle with lock_tgl_i high inverts the lock bit selected by lock_idx_i. Lock bits change at no other time. Bytes hidden by a lock keep their values.
- R10: An index at or above RAM_BYTES reads as 0xFF. A write there changes no RAM byte.
- R11: io_rdata_o is updated on the clock edge that samples io_re_i high. It holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_off_i | input | 2 | Window offset: 0 index low, 1 index high, 2 reserved, 3 data |
| io_we_i | input | 1 | Write strobe, one access per cycle |
| io_re_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, registered |
| lock_tgl_i | input | 1 | Toggle request for one lock bit |
| lock_idx_i | input | 1 | Lock bit selected by the toggle |

## Verification
The case that is hardest to reach is a hidden window whose contents must still be intact. Showing this needs three steps: a write to the window while it is hidden, a second toggle to open it, and a read that still sees the value stored before the lock. The stimulus fills every RAM byte with a value computed from its index. It then sweeps all indices with each lock on, tries to overwrite hidden bytes, and also pulses reset while a lock is set. After each step it reads the bytes back and compares them with the computed pattern.

// File: rtl/nvram_port_pkg.sv
package nvram_port_pkg;
  typedef enum logic [1:0] {
    OFF_IDX_LO = 2'd0,
    OFF_IDX_HI = 2'd1,
    OFF_RSVD   = 2'd2,
    OFF_DATA   = 2'd3
  } io_off_e;

  localparam int          IDX_W      = 16;
  localparam int          NUM_WIN    = 2;
  localparam int          WIN_SPAN   = 16;
  localparam logic [15:0] WIN_FIRST  = 16'h0020;
  localparam logic [7:0]  BLANK_BYTE = 8'hFF;

  function automatic logic [15:0] win_base(input int i);
    return WIN_FIRST + 16'(i * WIN_SPAN);
  endfunction
endpackage

// File: rtl/nvram_addr_latch.sv
module nvram_addr_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic              clr_i,
  input  logic [7:0]        wdata_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (clr_i)    addr_q <= '0;
    else if (lo_we_i)  addr_q[7:0] <= wdata_i;
    else if (hi_we_i)  addr_q[ADDR_W-1:8] <= wdata_i[HI_W-1:0];
  end

  assign addr_o = addr_q;

  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i && !clr_i |=> addr_q[ADDR_W-1:8] == $past(addr_q[ADDR_W-1:8])); // R2
  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i && !lo_we_i && !clr_i |=> addr_q[7:0] == $past(addr_q[7:0])); // R3
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> addr_o == '0); // R4
endmodule

// File: rtl/nvram_lock_ctrl.sv
module nvram_lock_ctrl
  import nvram_port_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgl_i,
  input  logic              tgl_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              blocked_o
);
  logic [NUM_WIN-1:0] lock_q;
  logic [NUM_WIN-1:0] hit;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(win_base(i));
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(win_base(i) + 16'(WIN_SPAN - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              lock_q[i] <= 1'b0;
      else if (tgl_i && (32'(tgl_idx_i) == i))  lock_q[i] <= ~lock_q[i];
    end

    assign hit[i] = lock_q[i] && (addr_i >= BASE) && (addr_i <= LAST);
  end

  assign blocked_o = |hit;

  AST_LOCK_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgl_i |=> $countones(lock_q ^ $past(lock_q)) == 1); // R9
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgl_i |=> $stable(lock_q)); // R9
endmodule

// File: rtl/nvram_store.sv
module nvram_store #(
  parameter int DEPTH = 256,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
  import nvram_port_pkg::*;
#(
  parameter int RAM_BYTES = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] io_off_i,
  input  logic       io_we_i,
  input  logic       io_re_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o,
  input  logic       lock_tgl_i,
  input  logic       lock_idx_i
);
  localparam int RAM_AW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;

  logic [IDX_W-1:0]  idx_q;
  logic              blocked;
  logic              in_range;
  logic              data_sel;
  logic              ram_we;
  logic [7:0]        ram_rd;
  logic [7:0]        rdata_q;

  assign data_sel = io_off_e'(io_off_i) == OFF_DATA;
  assign in_range = {1'b0, idx_q} < (IDX_W + 1)'(RAM_BYTES);
  assign ram_we   = io_we_i && data_sel && in_range && !blocked;

  nvram_addr_latch #(.ADDR_W(IDX_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_we_i (io_we_i && io_off_e'(io_off_i) == OFF_IDX_LO),
    .hi_we_i (io_we_i && io_off_e'(io_off_i) == OFF_IDX_HI),
    .clr_i   (io_we_i && data_sel),
    .wdata_i (io_wdata_i),
    .addr_o  (idx_q)
  );

  nvram_lock_ctrl #(.ADDR_W(IDX_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tgl_i     (lock_tgl_i),
    .tgl_idx_i (lock_idx_i),
    .addr_i    (idx_q),
    .blocked_o (blocked)
  );

  nvram_store #(.DEPTH(RAM_BYTES), .AW(RAM_AW)) u_store (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (idx_q[RAM_AW-1:0]),
    .wdata_i (io_wdata_i),
    .rdata_o (ram_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= BLANK_BYTE;
    else if (io_re_i)
      rdata_q <= (data_sel && in_range && !blocked) ? ram_rd : BLANK_BYTE;
  end

  assign io_rdata_o = rdata_q;

  AST_NONDATA_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_re_i && !data_sel |=> io_rdata_o == BLANK_BYTE); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_re_i |=> $stable(io_rdata_o)); // R11
  AST_BLOCKED_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |-> !ram_we); // R7
  AST_RANGE_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> !ram_we); // R10
endmodule

// File: tb/nvram_index_port_tb_top.sv
module nvram_index_port_tb_top;
  localparam int RAM_BYTES = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] off = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tgl = 1'b0, tidx = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_mem [RAM_BYTES];

  always #2 clk = ~clk;

  nvram_index_port #(.RAM_BYTES(RAM_BYTES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_off_i(off), .io_we_i(we), .io_re_i(re),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .lock_tgl_i(tgl), .lock_idx_i(tidx)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [1:0] o, input logic [7:0] v);
    @(negedge clk); off = o; wdata = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic io_rd(input logic [1:0] o, output logic [7:0] v);
    @(negedge clk); off = o; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic set_idx(input logic [15:0] a);
    io_wr(2'd0, a[7:0]);
    io_wr(2'd1, a[15:8]);
  endtask

  task automatic rd_at(input logic [15:0] a, output logic [7:0] v);
    set_idx(a);
    io_rd(2'd3, v);
  endtask

  task automatic toggle(input logic i);
    @(negedge clk); tgl = 1'b1; tidx = i;
    @(negedge clk); tgl = 1'b0;
  endtask

  function automatic logic [7:0] vis(input int a, input logic l0, input logic l1);
    if (a >= RAM_BYTES) return 8'hFF;
    if (l0 && a >= 16'h20 && a <= 16'h2F) return 8'hFF;
    if (l1 && a >= 16'h30 && a <= 16'h3F) return 8'hFF;
    return exp_mem[a];
  endfunction

  task automatic sweep(input string req, input logic l0, input logic l1);
    logic [7:0] v;
    for (int a = 0; a < RAM_BYTES; a++) begin
      rd_at(16'(a), v);
      check(req, v, vis(a, l0, l1));
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", rdata, 8'hFF);
    rst_n = 1'b1;

    // R1: index is zero after reset, so a bare data write lands at 0
    io_wr(2'd3, 8'hC3);
    rd_at(16'h0000, v);
    check("R1 index zero at reset", v, 8'hC3);

    // fill the whole RAM
    for (int a = 0; a < RAM_BYTES; a++) begin
      exp_mem[a] = pat(a);
      set_idx(16'(a));
      io_wr(2'd3, exp_mem[a]);
    end
    sweep("R5 readback", 1'b0, 1'b0);

    // R5: repeated read keeps index
    set_idx(16'h0042);
    io_rd(2'd3, v); check("R5 first read", v, exp_mem[8'h42]);
    io_rd(2'd3, v); check("R5 index kept by read", v, exp_mem[8'h42]);

    // R11: output holds without read
    repeat (4) @(negedge clk);
    check("R11 hold", rdata, exp_mem[8'h42]);

    // R2: low byte write keeps high byte
    set_idx(16'h0040);
    io_wr(2'd0, 8'h41);
    io_rd(2'd3, v); check("R2 low replace", v, exp_mem[8'h41]);
    set_idx(16'h0140);
    io_wr(2'd0, 8'h07);
    io_rd(2'd3, v); check("R2 high kept", v, 8'hFF);

    // R3: high byte write keeps low byte
    set_idx(16'h0105);
    io_rd(2'd3, v); check("R3 out of range before", v, 8'hFF);
    io_wr(2'd1, 8'h00);
    io_rd(2'd3, v); check("R3 low kept", v, exp_mem[8'h05]);

    // R4: data write clears index
    set_idx(16'h0010);
    exp_mem[8'h10] = 8'h5A;
    io_wr(2'd3, 8'h5A);
    io_rd(2'd3, v); check("R4 index cleared", v, exp_mem[0]);
    rd_at(16'h0010, v); check("R4 stored", v, 8'h5A);

    // R6: offset 2 write ignored, non-data reads blank
    set_idx(16'h0033);
    io_wr(2'd2, 8'h99);
    io_rd(2'd3, v); check("R6 off2 write ignored", v, exp_mem[8'h33]);
    for (int o = 0; o < 3; o++) begin
      io_rd(2'(o), v); check("R6 non-data read", v, 8'hFF);
    end

    // R7: lock 0
    toggle(1'b0);
    sweep("R7 lock0 sweep", 1'b1, 1'b0);
    set_idx(16'h0025); io_wr(2'd3, 8'h00);
    io_rd(2'd3, v); check("R7 index cleared after dropped write", v, exp_mem[0]);
    toggle(1'b0);
    rd_at(16'h0025, v); check("R9 lock0 contents kept", v, exp_mem[8'h25]);

    // R8: lock 1
    toggle(1'b1);
    sweep("R8 lock1 sweep", 1'b0, 1'b1);
    set_idx(16'h003F); io_wr(2'd3, 8'h11);
    toggle(1'b0);
    sweep("R9 both locks", 1'b1, 1'b1);
    toggle(1'b0);
    toggle(1'b1);
    rd_at(16'h003F, v); check("R9 lock1 contents kept", v, exp_mem[8'h3F]);

    // R1: reset clears locks, keeps RAM
    toggle(1'b1);
    rd_at(16'h0035, v); check("R8 locked before reset", v, 8'hFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check("R1 rdata reset mid-run", rdata, 8'hFF);
    rst_n = 1'b1;
    rd_at(16'h0035, v); check("R1 lock cleared, RAM kept", v, exp_mem[8'h35]);

    // R10: out of range
    set_idx(16'h0100); io_wr(2'd3, 8'hAA);
    set_idx(16'hFFFF); io_wr(2'd3, 8'hBB);
    rd_at(16'h0100, v); check("R10 out of range read", v, 8'hFF);
    rd_at(16'hFFFF, v); check("R10 top index read", v, 8'hFF);
    sweep("R10 no alias", 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule